// File: doc/BRIEF.md
# Counter-Matched Strobe Sequencer

The block produces seven control strobes whose rising and falling edges are placed on a free-running 7-bit step counter. Software or a controller sends 16-bit command words. Each command picks one of eight targets and writes a 7-bit match value to it. Target 0 is the counter's wrap limit. Targets 1 to 7 are strobes, and each of them has its own start value and its own stop value.

While the run input is high, the counter advances once per clock. After it reaches the programmed limit it returns to zero. On the cycle after the counter equals a strobe's start value, that strobe goes high. On the cycle after the counter equals its stop value, it goes low. If the two values are equal, stop wins. When run is low, the counter and all strobes freeze.

Top module: `pc_strobe_seq`

## Requirements
- R1: A command is accepted when `cmd_valid` is high and bits [15:11] of `cmd_word` equal 5'b00001. Bits [10:8] select the target (0 to 7), bit 7 is the stop flag (1 = stop value, 0 = start value), and bits [6:0] hold the match value. The write lands at the clock edge and is in force from the following cycle.
- R2: A command addressed to target 0 writes the counter limit, whatever the stop flag holds.
- R3: With `run` high, the counter goes to 0 on the edge after it equals the limit. Otherwise it increments by one, so a counter above the limit climbs to 127 and then wraps to 0.
- R4: With `run` low, neither the counter nor any strobe changes.
- R5: Strobe k (k = 1..7, output bit k-1) rises on the edge after the running counter equals its start value, unless R6 applies.
- R6: Strobe k falls on the edge after the running counter equals its stop value. When start and stop are equal, the strobe is driven low.
- R7: Reset sets the counter, the limit, every start and stop value, and every strobe to 0. Running straight after reset therefore keeps the counter at 0 and all strobes low.
- R8: Command words with any other value in bits [15:11] change no limit, start or stop value.
- R9: A command that lands in the same cycle as a counter match does not affect that cycle's match or wrap decision, which still uses the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Counter and strobe advance enable |
| cmd_valid | input | 1 | Command word present |
| cmd_word | input | 16 | Command word |
| pc_value | output | 7 | Current step counter |
| strobes | output | 7 | Strobe outputs, bit k-1 is target k |

## Verification
Two functions can fall in one cycle: a command write and a match or wrap decision that depends on the value being rewritten. The bench provokes this on purpose. It rewrites a stop value while the counter sits on the old stop, and it rewrites the limit while the counter sits on the old limit. It also mixes random commands with a mostly-running counter, so that such collisions happen often. A reference model applies each write only after it has evaluated the cycle's matches, and each outcome is judged against that model.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;
    localparam int PC_W    = 7;
    localparam int N_TGT   = 8;
    localparam int SEL_W   = $clog2(N_TGT);
    localparam int PFX_W   = 5;
    localparam int CMD_W   = PFX_W + SEL_W + 1 + PC_W;
    localparam int N_STRB  = N_TGT - 1;
    localparam logic [PFX_W-1:0] PFX_SEQ = 5'b00001;

    typedef logic [PC_W-1:0] pc_t;

    typedef struct packed {
        logic [PFX_W-1:0] pfx;
        logic [SEL_W-1:0] sel;
        logic             is_stop;
        pc_t              val;
    } cmd_t;

    typedef struct packed {
        logic             hit;
        logic [SEL_W-1:0] sel;
        logic             is_stop;
        pc_t              val;
    } wr_t;

    function automatic wr_t decode_cmd(input logic valid, input cmd_t c);
        wr_t w;
        w.hit     = valid && (c.pfx == PFX_SEQ);
        w.sel     = c.sel;
        w.is_stop = c.is_stop;
        w.val     = c.val;
        return w;
    endfunction

    function automatic pc_t pc_step(input pc_t cur, input pc_t lim);
        return (cur == lim) ? '0 : pc_t'(cur + pc_t'(1));
    endfunction
endpackage

// File: rtl/pcseq_decode.sv
module pcseq_decode
    import pcseq_pkg::*;
(
    input  logic             cmd_valid,
    input  logic [CMD_W-1:0] cmd_word,
    output logic             wr_limit,
    output logic [N_TGT-1:0] wr_start,
    output logic [N_TGT-1:0] wr_stop,
    output pc_t              wr_val
);
    wr_t w;

    always_comb begin
        w        = decode_cmd(cmd_valid, cmd_t'(cmd_word));
        wr_val   = w.val;
        wr_limit = w.hit && (w.sel == '0);
        wr_start = '0;
        wr_stop  = '0;
        for (int i = 1; i < N_TGT; i++) begin
            if (w.hit && (w.sel == SEL_W'(i))) begin
                wr_start[i] = !w.is_stop;
                wr_stop[i]  = w.is_stop;
            end
        end
    end
endmodule

// File: rtl/pcseq_counter.sv
module pcseq_counter
    import pcseq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic wr_limit,
    input  pc_t  wr_val,
    output pc_t  pc_q,
    output pc_t  limit_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q    <= '0;
            limit_q <= '0;
        end else begin
            if (run)
                pc_q <= pc_step(pc_q, limit_q);
            if (wr_limit)
                limit_q <= wr_val;
        end
    end
endmodule

// File: rtl/pcseq_strobe_cell.sv
module pcseq_strobe_cell
    import pcseq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  pc_t  pc,
    input  logic wr_start,
    input  logic wr_stop,
    input  pc_t  wr_val,
    output logic strb_q,
    output pc_t  start_q,
    output pc_t  stop_q
);
    logic hit_start, hit_stop;

    always_comb begin
        hit_start = (pc == start_q);
        hit_stop  = (pc == stop_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            strb_q  <= 1'b0;
            start_q <= '0;
            stop_q  <= '0;
        end else begin
            if (run) begin
                if (hit_stop)
                    strb_q <= 1'b0;
                else if (hit_start)
                    strb_q <= 1'b1;
            end
            if (wr_start)
                start_q <= wr_val;
            if (wr_stop)
                stop_q <= wr_val;
        end
    end
endmodule

// File: rtl/pc_strobe_seq.sv
module pc_strobe_seq
    import pcseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              cmd_valid,
    input  logic [CMD_W-1:0]  cmd_word,
    output logic [PC_W-1:0]   pc_value,
    output logic [N_STRB-1:0] strobes
);
    logic             wr_limit;
    logic [N_TGT-1:0] wr_start, wr_stop;
    pc_t              wr_val;
    pc_t              pc_q, limit_q;
    logic [N_STRB*PC_W-1:0] start_all, stop_all;

    pcseq_decode u_dec (
        .cmd_valid (cmd_valid),
        .cmd_word  (cmd_word),
        .wr_limit  (wr_limit),
        .wr_start  (wr_start),
        .wr_stop   (wr_stop),
        .wr_val    (wr_val)
    );

    pcseq_counter u_cnt (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .wr_limit (wr_limit),
        .wr_val   (wr_val),
        .pc_q     (pc_q),
        .limit_q  (limit_q)
    );

    for (genvar k = 1; k < N_TGT; k++) begin : g_strb
        pc_t s_start, s_stop;
        pcseq_strobe_cell u_cell (
            .clk      (clk),
            .rst      (rst),
            .run      (run),
            .pc       (pc_q),
            .wr_start (wr_start[k]),
            .wr_stop  (wr_stop[k]),
            .wr_val   (wr_val),
            .strb_q   (strobes[k-1]),
            .start_q  (s_start),
            .stop_q   (s_stop)
        );
        assign start_all[(k-1)*PC_W +: PC_W] = s_start;
        assign stop_all[(k-1)*PC_W +: PC_W]  = s_stop;
    end

    assign pc_value = pc_q;
endmodule

// File: rtl/pc_strobe_seq_chk.sv
module pc_strobe_seq_chk
    import pcseq_pkg::*;
(
    input logic                   clk,
    input logic                   rst,
    input logic                   run,
    input logic                   cmd_valid,
    input logic [CMD_W-1:0]       cmd_word,
    input logic [PC_W-1:0]        pc_value,
    input logic [N_STRB-1:0]      strobes,
    input logic [PC_W-1:0]        limit_q,
    input logic [N_STRB*PC_W-1:0] start_all,
    input logic [N_STRB*PC_W-1:0] stop_all
);
    logic bad_pfx;
    assign bad_pfx = cmd_valid && (cmd_word[CMD_W-1 -: PFX_W] != PFX_SEQ);

    a_r7_reset_state: assert property (@(posedge clk)
        rst |=> (pc_value == '0 && strobes == '0 && limit_q == '0));

    a_r3_wrap: assert property (@(posedge clk) disable iff (rst)
        (run && pc_value == limit_q) |=> (pc_value == '0));

    a_r3_incr: assert property (@(posedge clk) disable iff (rst)
        (run && pc_value != limit_q) |=> (pc_value == pc_t'($past(pc_value) + pc_t'(1))));

    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        !run |=> ($stable(pc_value) && $stable(strobes)));

    a_r8_ignore: assert property (@(posedge clk) disable iff (rst)
        bad_pfx |=> ($stable(limit_q) && $stable(start_all) && $stable(stop_all)));

    for (genvar k = 0; k < N_STRB; k++) begin : g_chk
        a_r6_fall: assert property (@(posedge clk) disable iff (rst)
            (run && pc_value == stop_all[k*PC_W +: PC_W]) |=> !strobes[k]);
        a_r5_rise: assert property (@(posedge clk) disable iff (rst)
            (run && pc_value == start_all[k*PC_W +: PC_W]
                 && pc_value != stop_all[k*PC_W +: PC_W]) |=> strobes[k]);
    end
endmodule

bind pc_strobe_seq pc_strobe_seq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .run       (run),
    .cmd_valid (cmd_valid),
    .cmd_word  (cmd_word),
    .pc_value  (pc_value),
    .strobes   (strobes),
    .limit_q   (limit_q),
    .start_all (start_all),
    .stop_all  (stop_all)
);

// File: tb/pc_strobe_seq_bench.sv
module pc_strobe_seq_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [15:0] cmd_word = '0;
    logic [6:0]  pc_value;
    logic [6:0]  strobes;

    int checks = 0;
    int errors = 0;

    logic [6:0] m_pc, m_lim;
    logic [6:0] m_start [8];
    logic [6:0] m_stop  [8];
    logic [6:0] m_strb;

    always #4 clk = ~clk;

    pc_strobe_seq u_pc_strobe_seq (
        .clk(clk), .rst(rst), .run(run), .cmd_valid(cmd_valid),
        .cmd_word(cmd_word), .pc_value(pc_value), .strobes(strobes)
    );

    function automatic logic [15:0] mk(input int sel, input bit stp, input int val);
        return {5'b00001, 3'(sel), stp, 7'(val)};
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_pc = '0; m_lim = '0; m_strb = '0;
        for (int i = 0; i < 8; i++) begin m_start[i] = '0; m_stop[i] = '0; end
    endtask

    // One cycle: drive at negedge, advance the model, compare at the next negedge
    task automatic step(input bit r, input bit v, input logic [15:0] w, input string tag);
        logic [6:0] npc, nstrb;
        run = r; cmd_valid = v; cmd_word = w;
        npc = m_pc; nstrb = m_strb;
        if (r) begin
            npc = (m_pc == m_lim) ? 7'd0 : 7'(m_pc + 7'd1);
            for (int k = 1; k < 8; k++) begin
                if (m_pc == m_stop[k]) nstrb[k-1] = 1'b0;
                else if (m_pc == m_start[k]) nstrb[k-1] = 1'b1;
            end
        end
        if (v && w[15:11] == 5'b00001) begin
            if (w[10:8] == 3'd0) m_lim = w[6:0];
            else if (w[7]) m_stop[w[10:8]] = w[6:0];
            else m_start[w[10:8]] = w[6:0];
        end
        m_pc = npc; m_strb = nstrb;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        check(pc_value == m_pc, {tag, " counter"}, pc_value, m_pc);
        check(strobes == m_strb, {tag, " strobes"}, strobes, m_strb);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(pc_value == 0, "R7 reset counter", pc_value, 0);
        check(strobes == 0, "R7 reset strobes", strobes, 0);

        // R7/R6: after reset the limit is 0 and start==stop==0, so nothing moves
        for (int i = 0; i < 4; i++) step(1, 0, '0, "R7 R6 idle-after-reset");

        // R1/R2: program limit 9 (stop flag set, still the limit), strobe 1 window 2..5, strobe 7 wraps 8..1
        step(0, 1, mk(0, 1, 9), "R2 limit write");
        step(0, 1, mk(1, 0, 2), "R1 start write");
        step(0, 1, mk(1, 1, 5), "R1 stop write");
        step(0, 1, mk(7, 0, 8), "R1 start write");
        step(0, 1, mk(7, 1, 1), "R1 stop write");
        step(0, 1, mk(3, 0, 4), "R6 equal start");
        step(0, 1, mk(3, 1, 4), "R6 equal stop");
        for (int i = 0; i < 24; i++) step(1, 0, '0, "R3 R5 R6 run");
        check(m_lim == 9, "R2 limit model", m_lim, 9);

        // R4: freeze mid-sequence
        for (int i = 0; i < 5; i++) step(0, 0, '0, "R4 hold");

        // R8: wrong prefix aimed at the limit and at strobe 1 stop
        step(1, 1, {5'b00011, 3'd0, 1'b0, 7'd3}, "R8 ignored");
        step(1, 1, {5'b10001, 3'd1, 1'b1, 7'd0}, "R8 ignored");
        for (int i = 0; i < 12; i++) step(1, 0, '0, "R8 after ignored");

        // R9: rewrite strobe 1 stop while the counter sits on the old stop
        while (m_pc != 7'd5) step(1, 0, '0, "R9 approach");
        step(1, 1, mk(1, 1, 7), "R9 stop rewrite at match");
        check(strobes[0] == 1'b0, "R9 old stop used", strobes[0], 0);
        // R9: rewrite the limit while the counter sits on the old limit
        while (m_pc != 7'd9) step(1, 0, '0, "R9 approach");
        step(1, 1, mk(0, 0, 20), "R9 limit rewrite at wrap");
        check(pc_value == 0, "R9 old limit used", pc_value, 0);

        // R3: lower the limit below the counter, counter climbs to 127 and wraps
        while (m_pc != 7'd12) step(1, 0, '0, "R3 approach");
        step(1, 1, mk(0, 0, 2), "R3 limit below counter");
        for (int i = 0; i < 120; i++) step(1, 0, '0, "R3 overflow wrap");

        // Random mix
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] w;
            bit r, v;
            r = ($urandom % 10) != 0;
            v = ($urandom % 4) == 0;
            w = mk($urandom % 8, $urandom % 2, ($urandom % 4 == 0) ? $urandom % 128 : $urandom % 24);
            if ($urandom % 8 == 0) w[15:11] = 5'($urandom);
            step(r, v, w, "R1 R3 R5 R6 R8 R9 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule